// File: doc/BRIEF.md
# I2C Master Control Register and Byte Sequencer

This block pairs one 8-bit control register with a byte-level I2C master. Software writes the register to open a transfer, to ask for a stop or a repeated start, and to choose the acknowledge level sent after each received byte. The sequencer drives open-drain SCL and SDA as drive-low enables. It produces START, address and data bytes, the acknowledge slot, repeated START and STOP. A quarter-bit divider paces it from the system clock.

Every byte is followed by an acknowledge slot. The sequencer then parks with SCL held low until software writes the start bit again. The first byte after any START is the slave address, and its least significant bit selects the direction of the data bytes that follow. The byte to send is taken from `tx_byte_i` when a byte begins. The last byte seen on SDA and the last acknowledge bit are presented on outputs.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset the register reads 0x00, and SCL and SDA are both released.
- R2: Register bit 0 (start) and bit 7 (ack level) read back as written. Bits 1 to 6 always read 0, and writes to bits 3 to 6 have no effect.
- R3: Writing 1 to bit 0 while enabled makes a START (SDA falls while SCL is high). The address byte follows MSB first, then a ninth clock in which the master releases SDA. The sequencer then raises `wait_o` and holds SCL low.
- R4: With `en_i` low, a write of 1 to bit 0 is ignored. The register stays 0 and both lines stay released.
- R5: Writing 1 to bit 0 during the wait sends the next byte, taken from `tx_byte_i`.
- R6: Writing 1 to bit 1 clears bit 0 in the next cycle and ends with a STOP (SDA rises while SCL is high). A request made during a byte takes effect after that byte's acknowledge slot.
- R7: Writing 1 to bit 2 is accepted only while bit 0 is 1. It then makes a repeated START followed by an address byte. While bit 0 is 0 it leaves the bus untouched.
- R8: If the address LSB is 1, the data bytes are received. In each acknowledge slot the master drives SDA low when bit 7 is 0 and releases it when bit 7 is 1. `rx_byte_o` then holds the received byte.
- R9: Writing 0 to bit 0 with bits 1 and 2 clear, while bit 0 is 1, aborts the transfer. By the next cycle both lines are released and `wait_o` is low.
- R10: Driving `en_i` low aborts any transfer. By the next cycle both lines are released and bit 0 is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Interface enable |
| reg_addr_i | input | ADDR_W | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (0 when the address does not match) |
| tx_byte_i | input | 8 | Byte sent in the next byte slot |
| rx_byte_o | output | 8 | Last byte seen on SDA |
| ack_in_o | output | 1 | SDA level sampled in the last acknowledge slot |
| wait_o | output | 1 | Parked after an acknowledge, SCL held low |
| scl_lo_o | output | 1 | Pull SCL low |
| sda_lo_o | output | 1 | Pull SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
A wrong state in the sequencer shows up on the bus itself. A lost START, a shifted bit or an acknowledge at the wrong level becomes a wrong or unexpected bus event, at the latest by the ninth SCL rise of the affected byte. A wrong register state shows up on the next read, one cycle after the write. It also shows as bus activity that should not happen, such as a repeated START or a transfer launched while disabled. Aborts are checked one cycle after their cause, by observing that both lines are released.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_BIT, ST_ACK, ST_WAIT, ST_STOP, ST_RSTART
  } bus_st_e;

  localparam int unsigned BIT_GO   = 0;
  localparam int unsigned BIT_STOP = 1;
  localparam int unsigned BIT_RS   = 2;
  localparam int unsigned BIT_ACK  = 7;
endpackage

// File: rtl/i2c_ctl_reg.sv
module i2c_ctl_reg
  import i2c_seq_pkg::*;
#(
  parameter int unsigned    ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hA3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              start_o,
  output logic              ack_lvl_o,
  output logic              go_p_o,
  output logic              stop_p_o,
  output logic              rs_p_o,
  output logic              abort_p_o
);
  logic hit, wr, start_q, ack_q, start_d;
  logic unused_rsvd;

  assign hit         = (addr_i == CTL_ADDR);
  assign wr          = we_i & hit;
  assign unused_rsvd = ^wdata_i[6:3];

  assign stop_p_o  = wr & wdata_i[BIT_STOP];
  assign rs_p_o    = wr & wdata_i[BIT_RS] & ~wdata_i[BIT_STOP] & start_q;
  assign go_p_o    = wr & wdata_i[BIT_GO] & ~wdata_i[BIT_STOP] & en_i;
  assign abort_p_o = wr & ~wdata_i[BIT_GO] & ~wdata_i[BIT_STOP] & ~wdata_i[BIT_RS] & start_q;

  always_comb begin
    start_d = start_q;
    if (!en_i)                   start_d = 1'b0;
    else if (wr) begin
      if (wdata_i[BIT_STOP])     start_d = 1'b0;
      else if (wdata_i[BIT_RS])  start_d = start_q;
      else                       start_d = wdata_i[BIT_GO];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      start_q <= start_d;
      if (wr) ack_q <= wdata_i[BIT_ACK];
    end
  end

  assign rdata_o   = hit ? {ack_q, 6'b0, start_q} : 8'h00;
  assign start_o   = start_q;
  assign ack_lvl_o = ack_q;
endmodule

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
  parameter int unsigned QTR_CYC = 25
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic tick_o
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (clr_i || cnt_q == LAST)  cnt_q <= '0;
    else                              cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = !clr_i && (cnt_q == LAST);
endmodule

// File: rtl/i2c_bus_fsm.sv
module i2c_bus_fsm
  import i2c_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       go_p_i,
  input  logic       stop_p_i,
  input  logic       rs_p_i,
  input  logic       abort_p_i,
  input  logic       ack_lvl_i,
  input  logic       tick_i,
  input  logic [7:0] tx_byte_i,
  input  logic       sda_i,
  output logic       scl_lo_o,
  output logic       sda_lo_o,
  output logic       wait_o,
  output logic       div_clr_o,
  output logic [7:0] rx_byte_o,
  output logic       ack_in_o
);
  bus_st_e    st_q;
  logic [1:0] q_q;
  logic [2:0] bcnt_q;
  logic [7:0] sh_q, rx_q;
  logic       samp_q, ack_q, rd_q, addr_q, stop_pend_q, rs_pend_q;
  logic       rxm, want_stop, want_rs, qend;

  assign rxm       = rd_q & ~addr_q;
  assign want_stop = stop_pend_q | stop_p_i;
  assign want_rs   = rs_pend_q | rs_p_i;
  assign qend      = tick_i && (q_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; q_q <= '0; bcnt_q <= '0; sh_q <= '0; rx_q <= '0;
      samp_q <= 1'b1; ack_q <= 1'b1; rd_q <= 1'b0; addr_q <= 1'b0;
      stop_pend_q <= 1'b0; rs_pend_q <= 1'b0;
    end else if (!en_i || abort_p_i) begin
      st_q <= ST_IDLE; q_q <= '0;
      stop_pend_q <= 1'b0; rs_pend_q <= 1'b0;
    end else begin
      if (stop_p_i) stop_pend_q <= 1'b1;
      if (rs_p_i)   rs_pend_q   <= 1'b1;
      if (tick_i) begin
        q_q <= q_q + 2'd1;
        if (q_q == 2'd2) samp_q <= sda_i;
      end
      unique case (st_q)
        ST_IDLE: begin
          stop_pend_q <= 1'b0; rs_pend_q <= 1'b0; q_q <= '0;
          if (go_p_i) st_q <= ST_START;
        end
        ST_WAIT: begin
          q_q <= '0;
          if (want_stop) begin
            st_q <= ST_STOP; stop_pend_q <= 1'b0; rs_pend_q <= 1'b0;
          end else if (want_rs) begin
            st_q <= ST_RSTART; rs_pend_q <= 1'b0;
          end else if (go_p_i) begin
            st_q <= ST_BIT; sh_q <= tx_byte_i; bcnt_q <= 3'd7;
          end
        end
        ST_START: if (qend) begin
          st_q <= ST_BIT; sh_q <= tx_byte_i; bcnt_q <= 3'd7;
          addr_q <= 1'b1; rd_q <= 1'b0;
        end
        ST_BIT: if (qend) begin
          sh_q <= {sh_q[6:0], samp_q};
          if (bcnt_q == 3'd0) begin
            st_q <= ST_ACK;
            rx_q <= {sh_q[6:0], samp_q};
          end else bcnt_q <= bcnt_q - 3'd1;
        end
        ST_ACK: if (qend) begin
          ack_q  <= samp_q;
          addr_q <= 1'b0;
          if (addr_q) rd_q <= rx_q[0];
          if (want_stop) begin
            st_q <= ST_STOP; stop_pend_q <= 1'b0; rs_pend_q <= 1'b0;
          end else if (want_rs) begin
            st_q <= ST_RSTART; rs_pend_q <= 1'b0;
          end else st_q <= ST_WAIT;
        end
        ST_STOP:   if (qend) st_q <= ST_IDLE;
        ST_RSTART: if (qend) st_q <= ST_START;
        default:   st_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    scl_lo_o = 1'b0;
    sda_lo_o = 1'b0;
    unique case (st_q)
      ST_START:  sda_lo_o = q_q[1];
      ST_BIT: begin
        scl_lo_o = ~q_q[1];
        sda_lo_o = rxm ? 1'b0 : ~sh_q[7];
      end
      ST_ACK: begin
        scl_lo_o = ~q_q[1];
        sda_lo_o = rxm & ~ack_lvl_i;
      end
      ST_WAIT:   scl_lo_o = 1'b1;
      ST_STOP: begin
        scl_lo_o = ~q_q[1];
        sda_lo_o = (q_q != 2'd3);
      end
      ST_RSTART: scl_lo_o = ~q_q[1];
      default: ;
    endcase
  end

  assign wait_o    = (st_q == ST_WAIT);
  assign div_clr_o = (st_q == ST_IDLE) || (st_q == ST_WAIT);
  assign rx_byte_o = rx_q;
  assign ack_in_o  = ack_q;
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq #(
  parameter int unsigned          ADDR_W   = 8,
  parameter logic [ADDR_W-1:0]    CTL_ADDR = 8'hA3,
  parameter int unsigned          QTR_CYC  = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [7:0]        tx_byte_i,
  output logic [7:0]        rx_byte_o,
  output logic              ack_in_o,
  output logic              wait_o,
  output logic              scl_lo_o,
  output logic              sda_lo_o,
  input  logic              sda_i
);
  logic ctl_start, ack_lvl, go_p, stop_p, rs_p, abort_p, tick, div_clr;

  i2c_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_reg (
    .clk_i, .rst_ni, .en_i,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .start_o(ctl_start), .ack_lvl_o(ack_lvl),
    .go_p_o(go_p), .stop_p_o(stop_p), .rs_p_o(rs_p), .abort_p_o(abort_p)
  );

  i2c_qtr_tick #(.QTR_CYC(QTR_CYC)) u_div (
    .clk_i, .rst_ni, .clr_i(div_clr), .tick_o(tick)
  );

  i2c_bus_fsm u_fsm (
    .clk_i, .rst_ni, .en_i,
    .go_p_i(go_p), .stop_p_i(stop_p), .rs_p_i(rs_p), .abort_p_i(abort_p),
    .ack_lvl_i(ack_lvl), .tick_i(tick), .tx_byte_i(tx_byte_i), .sda_i(sda_i),
    .scl_lo_o(scl_lo_o), .sda_lo_o(sda_lo_o), .wait_o(wait_o),
    .div_clr_o(div_clr), .rx_byte_o(rx_byte_o), .ack_in_o(ack_in_o)
  );
endmodule

// File: rtl/i2c_ctl_seq_chk.sv
module i2c_ctl_seq_chk #(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'hA3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [7:0]        reg_wdata_i,
  input logic [7:0]        rx_byte_o,
  input logic              wait_o,
  input logic              scl_lo_o,
  input logic              sda_lo_o,
  input logic              ctl_start
);
  logic wr;
  assign wr = reg_we_i && (reg_addr_i == CTL_ADDR);

  a_r6_stop_clears_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && reg_wdata_i[1] |=> !ctl_start);

  a_r10_disable_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !ctl_start && !scl_lo_o && !sda_lo_o);

  a_r9_abort_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && ctl_start && reg_wdata_i[2:0] == 3'b000 |=> !wait_o && !scl_lo_o && !sda_lo_o);

  a_r7_rs_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr && !ctl_start && !scl_lo_o && !sda_lo_o && reg_wdata_i[2:0] == 3'b100
    |=> !scl_lo_o && !sda_lo_o);

  a_r3_wait_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o && en_i && !reg_we_i |=> wait_o && scl_lo_o && $stable(rx_byte_o));
endmodule

bind i2c_ctl_seq i2c_ctl_seq_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
  .clk_i, .rst_ni, .en_i, .reg_addr_i, .reg_we_i, .reg_wdata_i,
  .rx_byte_o, .wait_o, .scl_lo_o, .sda_lo_o, .ctl_start
);

// File: tb/sim_i2c_ctl_seq.sv
`timescale 1ns/1ps
module sim_i2c_ctl_seq;
  localparam logic [7:0] A   = 8'hA3;
  localparam logic [7:0] RDB = 8'h96;
  localparam logic [1:0] EV_START = 2'd1, EV_BYTE = 2'd2, EV_STOP = 2'd3;

  logic clk = 0, rst_n = 0, en = 0, we = 0;
  logic [7:0] addr = A, wdata = 0, rdata, tx = 0, rxb;
  logic ack_in, wt, scl_lo, sda_lo, s_drv = 0;
  logic scl, sda;
  int n_chk = 0, n_bad = 0;
  logic [10:0] exp_q[$];
  int req_q[$];

  always #10 clk = ~clk;
  assign scl = ~scl_lo;
  assign sda = ~(sda_lo | s_drv);

  i2c_ctl_seq #(.QTR_CYC(4)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tx_byte_i(tx), .rx_byte_o(rxb),
    .ack_in_o(ack_in), .wait_o(wt), .scl_lo_o(scl_lo), .sda_lo_o(sda_lo), .sda_i(sda)
  );

  task automatic chk(input int r, input logic [10:0] got, input logic [10:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d got %h exp %h", r, got, exp);
    end
  endtask

  task automatic push(input int r, input logic [1:0] t, input logic [7:0] b, input logic a);
    exp_q.push_back({t, b, a});
    req_q.push_back(r);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic wait_w();
    while (!wt) @(negedge clk);
  endtask

  // monitor and slave model
  logic scl_p = 1, sda_p = 1, acked = 0, rd_s = 0;
  int bitn = 0, bidx = 0;
  logic [7:0] msh = 0;

  task automatic observe(input logic [10:0] ev);
    if (exp_q.size() == 0) begin
      n_chk++; n_bad++;
      $display("FAIL R3 unexpected bus event got %h exp none", ev);
    end else begin
      int r;
      logic [10:0] e;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      chk(r, ev, e);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl && scl_p && sda_p && !sda) begin
        observe({EV_START, 8'h00, 1'b0});
        bitn = 0; bidx = 0; rd_s = 0; s_drv = 0;
      end else if (scl && scl_p && !sda_p && sda) begin
        observe({EV_STOP, 8'h00, 1'b0});
        bitn = 0;
      end else if (scl && !scl_p) begin
        if (bitn < 8) msh = {msh[6:0], sda};
        else begin
          observe({EV_BYTE, msh, sda});
          if (bidx == 0) rd_s = msh[0];
          acked = !sda;
          bidx++;
        end
        bitn++;
      end else if (!scl && scl_p) begin
        if (bitn == 8) s_drv = (bidx == 0 || !rd_s);
        else if (bitn == 9) begin
          bitn = 0;
          s_drv = rd_s && acked && !RDB[7];
        end else if (bitn >= 1 && bitn <= 7 && rd_s && bidx > 0)
          s_drv = !RDB[7-bitn];
      end
    end
    scl_p = scl; sda_p = sda;
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired got hang exp completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(1, {3'b0, rdata}, 11'h000);                // R1 reset value
    chk(1, {9'b0, scl, sda}, 11'h003);             // R1 lines released

    // R4: start ignored while disabled
    wr(8'h01);
    chk(4, {3'b0, rdata}, 11'h000);
    repeat (50) @(negedge clk);
    chk(4, {9'b0, scl, sda}, 11'h003);

    // R3 + R2: start with reserved bits set
    en = 1; tx = 8'hA4;
    push(3, EV_START, 8'h00, 1'b0);
    push(3, EV_BYTE, 8'hA4, 1'b0);
    wr(8'h79);
    chk(2, {3'b0, rdata}, 11'h001);                // R2 reserved read 0
    wait_w();
    chk(3, {9'b0, wt, scl}, 11'h002);              // R3 parked, SCL low

    // R5: resume with next byte
    tx = 8'h3C;
    push(5, EV_BYTE, 8'h3C, 1'b0);
    wr(8'h01);
    wait_w();
    chk(5, {3'b0, rxb}, {3'b0, 8'h3C});

    // R7: repeated start to a read address
    tx = 8'hA5;
    push(7, EV_START, 8'h00, 1'b0);
    push(7, EV_BYTE, 8'hA5, 1'b0);
    wr(8'h05);
    wait_w();

    // R8: receive a byte, send NACK
    push(8, EV_BYTE, RDB, 1'b1);
    wr(8'h81);
    chk(2, {3'b0, rdata}, 11'h081);                // R2 ack bit readback
    wait_w();
    chk(8, {3'b0, rxb}, {3'b0, RDB});

    // R6: stop from wait
    push(6, EV_STOP, 8'h00, 1'b0);
    wr(8'h02);
    chk(6, {3'b0, rdata}, 11'h000);
    repeat (40) @(negedge clk);
    chk(6, {9'b0, scl, sda}, 11'h003);

    // R6: stop requested mid-byte
    tx = 8'hA4;
    push(6, EV_START, 8'h00, 1'b0);
    push(6, EV_BYTE, 8'hA4, 1'b0);
    push(6, EV_STOP, 8'h00, 1'b0);
    wr(8'h01);
    repeat (40) @(negedge clk);
    wr(8'h02);
    repeat (300) @(negedge clk);
    chk(6, {9'b0, scl, sda}, 11'h003);
    chk(6, {10'b0, wt}, 11'h000);

    // R7: repeated start ignored while start is 0
    wr(8'h04);
    repeat (100) @(negedge clk);
    chk(7, {9'b0, scl, sda}, 11'h003);
    chk(7, {3'b0, rdata}, 11'h000);

    // R9: abort by writing 0
    tx = 8'hFF;
    push(9, EV_START, 8'h00, 1'b0);
    wr(8'h01);
    repeat (40) @(negedge clk);
    wr(8'h00);
    chk(9, {8'b0, scl, sda, wt}, 11'h006);
    repeat (20) @(negedge clk);
    chk(9, {9'b0, scl, sda}, 11'h003);

    // R10: abort by disable
    push(10, EV_START, 8'h00, 1'b0);
    wr(8'h01);
    repeat (60) @(negedge clk);
    en = 0;
    @(negedge clk);
    chk(10, {9'b0, scl, sda}, 11'h003);
    chk(10, {3'b0, rdata}, 11'h000);
    en = 1;
    repeat (20) @(negedge clk);

    chk(3, 11'(exp_q.size()), 11'h000);            // R3 all bus events seen
    finish_run();
  end
endmodule